// File: doc/BRIEF.md
# Two-Coil Relay Bank Driver with Latch and Settle Timers

This block sits between a bank of stored output bits and the drivers of a bank of two-coil relays. Each channel gets a pair of coil drives that are always complementary. The set coil follows the output bit and the reset coil follows its inverse. A single output enable models the tri-state release of every coil drive in the bank. While the enable is low, the relays keep their last position and the output bits may change freely.

Cutting coil drive too soon after a command can let a relay fall back. For that reason a request to disable the bank is held off until a latch interval has elapsed since the last change of any output bit.

The block also watches the contact-sense inputs, which report a second set of contacts on each relay. A settle window restarts on every output change and whenever the bank is switched on. Once that window has expired, and only while the bank is driven, any sense bit that still differs from its output bit latches a per-channel mismatch flag. The flag stays set until reset.

The timing windows are given in microseconds and scaled by the clock rate in MHz. With the defaults, the latch interval is 7 ms and the settle window is 5.5 ms at 1 MHz.

Top module: `relay_coil_bank`

## Requirements
- R1: One clock edge after an output word is presented, `set_coil_o` equals that word and `rst_coil_o` equals its bitwise inverse, so no channel ever has both coils at 1.
- R2: While reset is asserted, and directly after it, the registered output word is all zeros: `set_coil_o` is 0, `rst_coil_o` is all ones, `coil_oe_o` is 0 and `mismatch_o` is 0.
- R3: When `bank_en_req_i` is 1 at a clock edge, `coil_oe_o` is 1 after that edge.
- R4: Every edge at which the output word differs from the registered word reloads a latch counter to LATCH_CYC (CLK_MHZ × LATCH_US). The counter counts down to 0 by one per edge. `coil_oe_o` falls only at an edge where the request is 0, the counter is already 0 and no change occurs. Drive therefore stays on for at least LATCH_CYC edges after the last change.
- R5: With no change pending and the latch counter at 0, dropping the request clears `coil_oe_o` at the next edge.
- R6: While `coil_oe_o` is 0, output changes still reach the coil outputs, and `coil_oe_o` stays 0 until requested.
- R7: A settle counter reloads to SETTLE_CYC (CLK_MHZ × SETTLE_US) on every output change and on every edge that turns the enable on. While the counter is nonzero, `mismatch_o` does not change.
- R8: At an edge where the settle counter is 0, the bank is enabled and no output change occurs, each channel whose `sense_i` bit differs from its registered output bit sets its `mismatch_o` bit. A sense value of 1 means the relay is activated. Other channels are unaffected.
- R9: While `coil_oe_o` is 0, `mismatch_o` does not change, whatever the sense inputs show.
- R10: Mismatch bits are sticky and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_bits_i | input | N | Stored output word, one bit per relay (1 = activate) |
| bank_en_req_i | input | 1 | Requested bank drive enable |
| sense_i | input | N | Contact-sense feedback, one bit per relay (1 = activated) |
| set_coil_o | output | N | Set-coil drive per channel |
| rst_coil_o | output | N | Reset-coil drive per channel |
| coil_oe_o | output | 1 | Effective drive enable of the bank (0 = coils released) |
| mismatch_o | output | N | Sticky per-channel contact mismatch flags |

## Verification
The bench drops the enable request in the same cycle as an output change. A design that honoured the request at once would release the coils while the relay is still latching, and `coil_oe_o` would fall early. Relays are modelled with random switching delays that run up to close to the settle window, so a window that is too short, or one not restarted when the bank is re-enabled, raises false flags. Outputs are changed while the bank is released and the contacts stay stale, so a monitor that ignores the enable flags those channels. A stuck contact on one channel must flag that channel alone, and the flag must survive the fault's removal.

// File: rtl/relay_coil_bank.sv
module relay_coil_bank #(
  parameter int N         = 8,
  parameter int CLK_MHZ   = 1,
  parameter int LATCH_US  = 7000,
  parameter int SETTLE_US = 5500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] out_bits_i,
  input  logic         bank_en_req_i,
  input  logic [N-1:0] sense_i,
  output logic [N-1:0] set_coil_o,
  output logic [N-1:0] rst_coil_o,
  output logic         coil_oe_o,
  output logic [N-1:0] mismatch_o
);
  localparam int LATCH_CYC  = CLK_MHZ * LATCH_US;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int LW = $clog2(LATCH_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [N-1:0]  out_q;
  logic [N-1:0]  flag_q;
  logic [LW-1:0] lat_cnt;
  logic [SW-1:0] set_cnt;
  logic          en_q;

  wire chg      = out_bits_i != out_q;
  wire en_rise  = bank_en_req_i & ~en_q;
  wire lat_done = lat_cnt == '0;
  wire win_open = (set_cnt == '0) && en_q && !chg;

  assign set_coil_o = out_q;
  assign rst_coil_o = ~out_q;
  assign coil_oe_o  = en_q;
  assign mismatch_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_bits_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
    end else if (chg) begin
      lat_cnt <= LW'(LATCH_CYC);
    end else if (!lat_done) begin
      lat_cnt <= lat_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (bank_en_req_i) begin
      en_q <= 1'b1;
    end else if (lat_done && !chg) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_cnt <= '0;
    end else if (chg || en_rise) begin
      set_cnt <= SW'(SETTLE_CYC);
    end else if (set_cnt != '0) begin
      set_cnt <= set_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (win_open) begin
      flag_q <= flag_q | (sense_i ^ out_q);
    end
  end

  p_coil_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (set_coil_o == $past(out_bits_i)) && (rst_coil_o == ~$past(out_bits_i)));

  p_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en_req_i |=> coil_oe_o);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_oe_o && (!lat_done || chg)) |=> coil_oe_o);

  p_settle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cnt != '0) |=> (mismatch_o == $past(mismatch_o)));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !coil_oe_o |=> $stable(mismatch_o));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((mismatch_o & $past(mismatch_o)) == $past(mismatch_o)));
endmodule

// File: tb/tb_relay_coil_bank.sv
`timescale 1ns/1ps
module tb_relay_coil_bank;
  localparam int N = 8;
  localparam int L = 40;
  localparam int S = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] out_bits = '0;
  logic req = 1'b0;
  logic [N-1:0] contact = '0;
  logic [N-1:0] stuck = '0;
  logic [N-1:0] set_coil, rst_coil, mis;
  logic oe;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  relay_coil_bank #(.N(N), .CLK_MHZ(1), .LATCH_US(L), .SETTLE_US(S)) dut (
    .clk(clk), .rst_n(rst_n), .out_bits_i(out_bits), .bank_en_req_i(req),
    .sense_i(contact), .set_coil_o(set_coil), .rst_coil_o(rst_coil),
    .coil_oe_o(oe), .mismatch_o(mis));

  always #2.5 clk = ~clk;

  logic [N-1:0] m_out = '0, m_mis = '0;
  logic m_en = 1'b0;
  int m_lat = 0, m_set = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_mis = '0; m_en = 1'b0; m_lat = 0; m_set = 0;
    end else begin
      bit chg, rise, lat_zero, win;
      chg = (out_bits != m_out);
      rise = req && !m_en;
      lat_zero = (m_lat == 0);
      win = (m_set == 0) && m_en && !chg;
      if (win) m_mis = m_mis | (contact ^ m_out);
      if (chg || rise) m_set = S; else if (m_set > 0) m_set--;
      if (chg) m_lat = L; else if (m_lat > 0) m_lat--;
      if (req) m_en = 1'b1; else if (lat_zero && !chg) m_en = 1'b0;
      m_out = out_bits;
    end
  end

  int pend [N];
  initial for (int i = 0; i < N; i++) pend[i] = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (stuck[i]) pend[i] = -1;
        else if (oe && set_coil[i] != contact[i]) begin
          if (pend[i] < 0) pend[i] = $urandom_range(S - 5, 1);
          else if (pend[i] <= 1) begin contact[i] = set_coil[i]; pend[i] = -1; end
          else pend[i]--;
        end else pend[i] = -1;
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (set_coil !== m_out || rst_coil !== ~m_out) begin
      fails++;
      $display("FAIL R1 coils set=%h rst=%h expected set=%h rst=%h", set_coil, rst_coil, m_out, ~m_out);
    end
    if (oe !== m_en) begin
      fails++;
      $display("FAIL R4 coil_oe=%b expected %b", oe, m_en);
    end
    if (mis !== m_mis) begin
      fails++;
      $display("FAIL R8 mismatch=%h expected %h", mis, m_mis);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wt(3);
    chk("R2 set_coil", set_coil, '0);
    chk("R2 rst_coil", rst_coil, '1);
    chk("R2 coil_oe", N'(oe), '0);
    chk("R2 mismatch", mis, '0);
    rst_n = 1'b1;
    wt(2);
    req = 1'b1;
    wt(1);
    chk("R3 enable on", N'(oe), N'(1));
    out_bits = 8'hA5;
    wt(60);
    chk("R8 clean relays", mis, '0);
    chk("R1 set follows", set_coil, 8'hA5);
    out_bits = 8'h5A; req = 1'b0;
    wt(L / 2);
    chk("R4 held mid latch", N'(oe), N'(1));
    wt(L / 2 + 3);
    chk("R4 released after latch", N'(oe), '0);
    req = 1'b1;
    wt(60);
    req = 1'b0;
    wt(1);
    chk("R5 immediate release", N'(oe), '0);
    out_bits = 8'hFF;
    wt(60);
    chk("R6 enable stays off", N'(oe), '0);
    chk("R6 coils follow", set_coil, 8'hFF);
    chk("R9 no flag disabled", mis, '0);
    req = 1'b1;
    wt(S / 2);
    chk("R7 quiet in window", mis, '0);
    wt(60);
    chk("R7 relays settled", mis, '0);
    stuck[3] = 1'b1;
    out_bits = 8'hF7;
    wt(S - 5);
    chk("R7 no flag yet", mis, '0);
    wt(15);
    chk("R8 stuck channel flagged", mis, 8'h08);
    out_bits = 8'hFF; stuck[3] = 1'b0;
    wt(100);
    chk("R10 flag sticky", mis, 8'h08);
    for (int k = 0; k < 300; k++) begin
      out_bits = N'($urandom);
      if ($urandom_range(3, 0) == 0) req = ~req;
      wt($urandom_range(70, 1));
    end
    req = 1'b0;
    wt(L + 5);
    chk("R4 final release", N'(oe), '0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule